// File: doc/BRIEF.md
# DMA Completion Code Interrupt Tracker

This block turns transfer-completion reports from a DMA transfer engine into interrupt requests. Each transfer arrives with a 6-bit completion code, a flag that says whether the completion should raise an interrupt, and a mode flag. In early mode the code is posted in the cycle the engine reports that the last write command went out. In normal mode the transfer is parked in a small in-order queue and its code is posted only when the destination acknowledges the last write. Each destination acknowledgment retires the oldest parked transfer.

A posted code sets the pending bit with the same index in a 64-bit pending vector, which software sees as a low and a high 32-bit word. A 64-bit enable vector masks the pending vector onto a single registered interrupt line. A small register port lets software read both vectors, clear pending bits by writing ones, and set or clear enable bits by writing ones to separate addresses.

Top module: `xfer_done_irq`

## Requirements
- R1: A posted code c sets pending bit c. Bits 0..31 read at register address 0 and bits 32..63 at address 1 (bit c-32 of that word); addresses 2 and 3 read the same two words.
- R2: A transfer whose interrupt flag (issueIntEn) is 0 sets no pending bit, in either mode, and still takes its place in the normal-mode queue.
- R3: With issueEarly=1, an issue pulse with issueIntEn=1 sets the pending bit at the next rising clock edge, without waiting for any acknowledgment.
- R4: With issueEarly=0, the issue pulse sets no pending bit; each ackValid pulse retires the oldest queued transfer in issue order and sets its pending bit at the next edge. An early post and an acknowledgment post in the same cycle both take effect.
- R5: The queue holds at most 4 transfers. A normal-mode issue while 4 are queued and no acknowledgment arrives in that cycle is dropped; an acknowledgment with an empty queue has no effect.
- R6: A register write to address 2 (low word) or 3 (high word) clears every pending bit written as 1 at the next edge. When a post and a clear hit the same bit in the same cycle, the bit ends set.
- R7: A write to address 4 or 5 sets the enable bits written as 1 (low or high word); a write to address 6 or 7 clears them. Addresses 4 and 6 read the low enable word, 5 and 7 the high one. Other enable bits are unchanged.
- R8: irq is a register that, at each edge, takes the OR of (pending AND enable) as held before that edge; it falls one cycle after the last enabled pending bit or its enable is cleared.
- R9: A cycle with rst=1 clears all pending bits, all enable bits, irq, and the queue, at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | Last write command of a transfer issued |
| issueCode | input | 6 | Completion code of that transfer |
| issueIntEn | input | 1 | 1: completion raises a pending bit |
| issueEarly | input | 1 | 1: post at issue; 0: post at destination acknowledgment |
| ackValid | input | 1 | Destination acknowledged the last write of the oldest normal-mode transfer |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest states to reach are the queue at capacity meeting an issue, and a post colliding with a clear of the same bit in one cycle. The bench fills the queue with back-to-back normal-mode issues, offers a fifth that must vanish, then drains it with acknowledgments and checks the order of the bits that appear. For the collisions it drives an early issue and a clear write, or an early issue and an acknowledgment, in the same clock cycle so that both strobes reach the pending vector together.

// File: rtl/xfer_done_pkg.sv
package xfer_done_pkg;
  localparam int CODE_W     = 6;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 3;
  localparam int NUM_CODES  = 1 << CODE_W;
  localparam int NUM_HALVES = NUM_CODES / REG_W;

  // strobes from control to datapath
  typedef struct packed {
    logic              setA;
    logic [CODE_W-1:0] codeA;
    logic              setB;
    logic [CODE_W-1:0] codeB;
    logic              pendClr;
    logic              enSet;
    logic              enClr;
    logic              half;
    logic [REG_W-1:0]  wdata;
  } ctrlStrobes_t;
endpackage

// File: rtl/xfer_done_fifo.sv
module xfer_done_fifo #(
  parameter int DATA_W = 7,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic              full, doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign doPop    = pop & ~empty;
  assign doPush   = push & (~full | doPop);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/xfer_done_ctrl.sv
module xfer_done_ctrl
  import xfer_done_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic [CODE_W-1:0] issueCode,
  input  logic              issueIntEn,
  input  logic              issueEarly,
  input  logic              ackValid,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output ctrlStrobes_t      strb,
  output logic [CNT_W-1:0]  qCount
);
  localparam int QW = CODE_W + 1;

  logic [QW-1:0] headEntry;
  logic          qEmpty;

  xfer_done_fifo #(.DATA_W(QW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (issueValid & ~issueEarly),
    .pop      (ackValid),
    .pushData ({issueIntEn, issueCode}),
    .headData (headEntry),
    .count    (qCount),
    .empty    (qEmpty)
  );

  always_comb begin
    strb         = '0;
    // early completion posts straight from the issue report
    strb.setA    = issueValid & issueEarly & issueIntEn;
    strb.codeA   = issueCode;
    // normal completion posts the oldest queued code on acknowledgment
    strb.setB    = ackValid & ~qEmpty & headEntry[QW-1];
    strb.codeB   = headEntry[CODE_W-1:0];
    strb.pendClr = regWrEn & (regAddr[2:1] == 2'b01);
    strb.enSet   = regWrEn & (regAddr[2:1] == 2'b10);
    strb.enClr   = regWrEn & (regAddr[2:1] == 2'b11);
    strb.half    = regAddr[0];
    strb.wdata   = regWrData;
  end
endmodule

// File: rtl/xfer_done_dp.sv
module xfer_done_dp
  import xfer_done_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strb,
  input  logic [ADDR_W-1:0]    regAddr,
  output logic [NUM_CODES-1:0] pendAll,
  output logic [NUM_CODES-1:0] enAll,
  output logic [REG_W-1:0]     regRdData,
  output logic                 irq
);
  logic [NUM_CODES-1:0] setMask, pendClrMask, enSetMask, enClrMask;
  logic [REG_W-1:0]     pendHalves [NUM_HALVES];
  logic [REG_W-1:0]     enHalves   [NUM_HALVES];

  always_comb begin
    setMask = '0;
    if (strb.setA) setMask[strb.codeA] = 1'b1;
    if (strb.setB) setMask[strb.codeB] = 1'b1;
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic hit;
    assign hit = (strb.half == 1'(h));
    assign pendClrMask[h*REG_W +: REG_W] = (strb.pendClr && hit) ? strb.wdata : '0;
    assign enSetMask[h*REG_W +: REG_W]   = (strb.enSet   && hit) ? strb.wdata : '0;
    assign enClrMask[h*REG_W +: REG_W]   = (strb.enClr   && hit) ? strb.wdata : '0;
    assign pendHalves[h] = pendAll[h*REG_W +: REG_W];
    assign enHalves[h]   = enAll[h*REG_W +: REG_W];
  end

  assign regRdData = regAddr[2] ? enHalves[regAddr[0]] : pendHalves[regAddr[0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      pendAll <= '0;
      enAll   <= '0;
      irq     <= 1'b0;
    end else begin
      pendAll <= (pendAll & ~pendClrMask) | setMask;
      enAll   <= (enAll | enSetMask) & ~enClrMask;
      irq     <= |(pendAll & enAll);
    end
  end
endmodule

// File: rtl/xfer_done_irq.sv
module xfer_done_irq
  import xfer_done_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic [CODE_W-1:0] issueCode,
  input  logic              issueIntEn,
  input  logic              issueEarly,
  input  logic              ackValid,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ctrlStrobes_t         strb;
  logic [CNT_W-1:0]     qCount;
  logic [NUM_CODES-1:0] pendAll, enAll;

  xfer_done_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .issueCode  (issueCode),
    .issueIntEn (issueIntEn),
    .issueEarly (issueEarly),
    .ackValid   (ackValid),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strb       (strb),
    .qCount     (qCount)
  );

  xfer_done_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .regAddr   (regAddr),
    .pendAll   (pendAll),
    .enAll     (enAll),
    .regRdData (regRdData),
    .irq       (irq)
  );
endmodule

// File: rtl/xfer_done_chk.sv
module xfer_done_chk
  import xfer_done_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 issueValid,
  input logic [CODE_W-1:0]    issueCode,
  input logic                 issueIntEn,
  input logic                 issueEarly,
  input logic                 ackValid,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [NUM_CODES-1:0] pendAll,
  input logic [NUM_CODES-1:0] enAll,
  input logic [CNT_W-1:0]     qCount,
  input logic                 irq
);
  // R3 (with the set-wins rule of R6): an early post is visible next cycle
  p_early_post_r3: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueEarly && issueIntEn) |=> pendAll[$past(issueCode)]);

  // R5: the queue never exceeds its capacity
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    qCount <= CNT_W'(DEPTH));

  // R5: acknowledgment on an empty queue with no issue leaves it empty
  p_empty_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (qCount == '0 && !(issueValid && !issueEarly)) |=> qCount == '0);

  // R7: enables move only on enable writes
  p_enable_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr[2]) |=> $stable(enAll));

  // R8: interrupt follows masked pending with one cycle of lag
  p_irq_lag_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(pendAll & enAll)));

  // R9: reset leaves everything cleared
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (pendAll == '0 && enAll == '0 && !irq && qCount == '0));
endmodule

bind xfer_done_irq xfer_done_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issueValid (issueValid),
  .issueCode  (issueCode),
  .issueIntEn (issueIntEn),
  .issueEarly (issueEarly),
  .ackValid   (ackValid),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .pendAll    (pendAll),
  .enAll      (enAll),
  .qCount     (qCount),
  .irq        (irq)
);

// File: tb/xfer_done_irq_bench.sv
module xfer_done_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        issueValid, issueIntEn, issueEarly, ackValid, regWrEn;
  logic [5:0]  issueCode;
  logic [2:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        irq;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xfer_done_irq u_xfer_done_irq (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueCode(issueCode),
    .issueIntEn(issueIntEn), .issueEarly(issueEarly), .ackValid(ackValid),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  function automatic logic [63:0] bitOf(input int c);
    return 64'd1 << c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic readPend(output logic [63:0] p);
    logic [31:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    p = {hi, lo};
  endtask

  task automatic readEn(output logic [63:0] e);
    logic [31:0] lo, hi;
    rd(3'd4, lo);
    rd(3'd5, hi);
    e = {hi, lo};
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic issue(input int code, input logic intEn, input logic early);
    @(negedge clk);
    issueValid = 1'b1; issueCode = 6'(code); issueIntEn = intEn; issueEarly = early;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    ackValid = 1'b1;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic clearAll();
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [63:0] p, e;
    readPend(p);
    readEn(e);
    check("R9 pending after reset", p, 64'd0);
    check("R9 enable after reset", e, 64'd0);
    check("R9 irq after reset", 64'(irq), 64'd0);
  endtask

  task automatic t_early_map();
    logic [63:0] p;
    logic [31:0] w;
    issue(0, 1'b1, 1'b1);
    readPend(p);
    check("R3 early post code 0 next edge", p, bitOf(0));
    issue(31, 1'b1, 1'b1);
    issue(32, 1'b1, 1'b1);
    issue(63, 1'b1, 1'b1);
    readPend(p);
    check("R1 codes 0,31,32,63", p, bitOf(0) | bitOf(31) | bitOf(32) | bitOf(63));
    rd(3'd1, w);
    check("R1 high word code 32 at bit 0", 64'(w), 64'h8000_0001);
    rd(3'd2, w);
    check("R1 address 2 mirrors low word", 64'(w), 64'h8000_0001);
    clearAll();
  endtask

  task automatic t_int_disabled();
    logic [63:0] p;
    issue(12, 1'b0, 1'b1);
    readPend(p);
    check("R2 early with flag off", p, 64'd0);
    issue(13, 1'b0, 1'b0);
    issue(14, 1'b1, 1'b0);
    ack();
    readPend(p);
    check("R2 normal with flag off retires silently", p, 64'd0);
    ack();
    readPend(p);
    check("R2 next queued entry still posts", p, bitOf(14));
    clearAll();
  endtask

  task automatic t_normal_order();
    logic [63:0] p;
    issue(5, 1'b1, 1'b0);
    issue(40, 1'b1, 1'b0);
    issue(7, 1'b1, 1'b0);
    readPend(p);
    check("R4 no post before ack", p, 64'd0);
    ack();
    readPend(p);
    check("R4 first ack posts oldest", p, bitOf(5));
    ack();
    readPend(p);
    check("R4 second ack", p, bitOf(5) | bitOf(40));
    ack();
    readPend(p);
    check("R4 third ack", p, bitOf(5) | bitOf(40) | bitOf(7));
    clearAll();
    issue(20, 1'b1, 1'b0);
    @(negedge clk);
    issueValid = 1'b1; issueCode = 6'd50; issueIntEn = 1'b1; issueEarly = 1'b1;
    ackValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0; ackValid = 1'b0;
    readPend(p);
    check("R4 early and ack posts in one cycle", p, bitOf(20) | bitOf(50));
    clearAll();
  endtask

  task automatic t_queue_full();
    logic [63:0] p;
    for (int i = 0; i < 5; i++) issue(10 + i, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) ack();
    readPend(p);
    check("R5 fifth issue dropped when full", p, bitOf(10) | bitOf(11) | bitOf(12) | bitOf(13));
    clearAll();
    ack();
    readPend(p);
    check("R5 ack on empty queue no effect", p, 64'd0);
    issue(44, 1'b1, 1'b0);
    ack();
    readPend(p);
    check("R5 queue usable after empty ack", p, bitOf(44));
    clearAll();
  endtask

  task automatic t_set_wins();
    logic [63:0] p;
    issue(9, 1'b1, 1'b1);
    issue(4, 1'b1, 1'b1);
    @(negedge clk);
    issueValid = 1'b1; issueCode = 6'd9; issueIntEn = 1'b1; issueEarly = 1'b1;
    regWrEn = 1'b1; regAddr = 3'd2; regWrData = 32'h0000_0210;
    @(negedge clk);
    issueValid = 1'b0; regWrEn = 1'b0;
    readPend(p);
    check("R6 set wins over clear on same bit", p, bitOf(9));
    wr(3'd2, 32'h0000_0200);
    readPend(p);
    check("R6 clear alone", p, 64'd0);
  endtask

  task automatic t_enable_irq();
    logic [63:0] e;
    logic [31:0] w;
    issue(33, 1'b1, 1'b1);
    @(negedge clk);
    check("R8 no irq with enables off", 64'(irq), 64'd0);
    wr(3'd5, 32'h0000_0002);
    readEn(e);
    check("R7 enable set high word", e, bitOf(33));
    rd(3'd7, w);
    check("R7 address 7 reads high enables", 64'(w), 64'h2);
    check("R8 irq lags enable by one cycle", 64'(irq), 64'd0);
    @(negedge clk);
    check("R8 irq rises", 64'(irq), 64'd1);
    wr(3'd4, 32'h0000_0001);
    readEn(e);
    check("R7 enable set other bit keeps rest", e, bitOf(33) | bitOf(0));
    wr(3'd3, 32'h0000_0002);
    check("R8 irq still high one cycle after clear", 64'(irq), 64'd1);
    @(negedge clk);
    check("R8 irq falls", 64'(irq), 64'd0);
    issue(33, 1'b1, 1'b1);
    @(negedge clk);
    check("R8 irq back", 64'(irq), 64'd1);
    wr(3'd7, 32'h0000_0002);
    readEn(e);
    check("R7 enable clear single bit", e, bitOf(0));
    @(negedge clk);
    check("R8 irq falls after enable clear", 64'(irq), 64'd0);
  endtask

  task automatic t_reset_mid();
    logic [63:0] p, e;
    issue(3, 1'b1, 1'b1);
    wr(3'd4, 32'h0000_0008);
    issue(22, 1'b1, 1'b0);
    doReset();
    readPend(p);
    readEn(e);
    check("R9 reset clears pending", p, 64'd0);
    check("R9 reset clears enables", e, 64'd0);
    check("R9 reset clears irq", 64'(irq), 64'd0);
    ack();
    readPend(p);
    check("R9 reset empties queue", p, 64'd0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    issueValid = 1'b0; issueCode = '0; issueIntEn = 1'b0; issueEarly = 1'b0;
    ackValid = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_early_map();
    t_int_disabled();
    t_normal_order();
    t_queue_full();
    t_set_wins();
    t_enable_irq();
    t_reset_mid();
    finish();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end
endmodule